// File: doc/BRIEF.md
# Video Stream Signature Analyzer

This block sits on the outgoing 8-bit pixel path and folds every active-display byte into a 16-bit signature held in a multiple-input linear feedback shift register. The signature keeps running across every scan line of a frame. It returns to zero only when vertical sync falls, so a single value describes the whole frame. Moving a window or changing one bitmap byte gives a different value. Two identical lines at different heights also change it in different ways.

The video output pins pass pixels through during active display. During blanking the pins show one of two values. In test mode with the output enable set, they show one half of the live signature, and horizontal sync picks the half. Otherwise they show a programmable default video byte. Accumulation runs in every mode. A readback register takes a copy of the signature when vertical sync rises, so a processor can read a stable full-frame value throughout vertical blanking.

Top module: `vidSigAnalyzer`

## Requirements
- R1: While `rst` is high at a clock edge, the signature, `sigRead` and `vidOut` all become zero.
- R2: When `blank` is low at a clock edge, `vidOut` carries that cycle's `vidIn` byte after the edge. This holds whatever the values of `testMode` and `sigOutEn`.
- R3: When `blank` is low at an edge and vertical sync is not falling, the signature S is updated. Feedback f is S[15]^S[13]^S[12]^S[10], the taps of x^16+x^14+x^13+x^11+1. The new value is {S[14:0], f} XOR {8'h00, vidIn}.
- R4: When `blank` is high and vertical sync is not falling, the signature keeps its value.
- R5: The signature is not cleared at scan-line boundaries, so it accumulates over all lines of a frame.
- R6: At an edge where `vsync` is low and it was high at the previous edge, the signature becomes zero. This clear takes priority over accumulation.
- R7: When `blank`, `testMode` and `sigOutEn` are all high at an edge, `vidOut` shows a half of the current signature after the edge. It shows bits [7:0] if `hsync` is low and bits [15:8] if `hsync` is high.
- R8: When `blank` is high and `testMode` or `sigOutEn` is low, `vidOut` shows `defaultVideo` after the edge.
- R9: `sigRead` loads the current signature at an edge where `vsync` is high and it was low at the previous edge. It keeps its value at all other edges.
- R10: Accumulation and readback behave the same with `testMode` low. A frame run outside test mode yields the same `sigRead` as the same frame run in test mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous active-high reset |
| vidIn | input | 8 | Outgoing video data byte |
| blank | input | 1 | High during horizontal or vertical blanking |
| hsync | input | 1 | Horizontal sync, active high; picks the signature half |
| vsync | input | 1 | Vertical sync, active high; falling edge clears, rising edge captures |
| testMode | input | 1 | Test mode flag |
| sigOutEn | input | 1 | Enables the signature on the pins during blanking in test mode |
| defaultVideo | input | 8 | Byte shown during blanking when the signature is not shown |
| vidOut | output | 8 | Registered video output pins |
| sigRead | output | 16 | Signature captured at the start of vertical blanking |

## Verification
The bench builds the block with its default widths: an 8-bit pixel and a 16-bit signature, the two halves matching the pin width exactly. It runs short frames of a few lines. This keeps every line-boundary blanking interval, both sync edges and the pixel-to-signature path within a few hundred cycles. Frames run in test mode, outside test mode and with identical lines. The behavioural model then checks each blanking half-byte, each clear and each capture on every clock.

// File: rtl/vidSigPkg.sv
package vidSigPkg;

  // Strobes from the control module to the datapath for one video clock.
  typedef struct packed {
    logic accumEn;    // fold the current pixel into the signature
    logic clearSig;   // zero the signature (frame start)
    logic captureRd;  // copy the signature into the readback register
    logic showSig;    // blanking output takes the signature, not the default
    logic selHigh;    // pick the upper signature half
  } sigStrobes_t;

endpackage

// File: rtl/vidSigCtrl.sv
module vidSigCtrl
  import vidSigPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        blank,
  input  logic        hsync,
  input  logic        vsync,
  input  logic        testMode,
  input  logic        sigOutEn,
  output sigStrobes_t strobes
);

  // Previous vsync sample; tracks the pin even through reset so that an
  // edge seen right after reset is a real edge on the pin.
  logic vsyncQ;

  always_ff @(posedge clk) begin
    vsyncQ <= vsync;
  end

  logic vsyncFall;
  logic vsyncRise;

  always_comb begin
    vsyncFall = vsyncQ & ~vsync;
    vsyncRise = ~vsyncQ & vsync;
  end

  always_comb begin
    strobes           = '0;
    strobes.clearSig  = vsyncFall & ~rst;
    strobes.accumEn   = ~blank & ~vsyncFall & ~rst;
    strobes.captureRd = vsyncRise & ~rst;
    strobes.showSig   = testMode & sigOutEn;
    strobes.selHigh   = hsync;
  end

endmodule

// File: rtl/vidSigDatapath.sv
module vidSigDatapath
  import vidSigPkg::*;
#(
  parameter int          DATA_W = 8,
  parameter int          SIG_W  = 16,
  parameter logic [15:0] TAPS   = 16'hB400
) (
  input  logic              clk,
  input  logic              rst,
  input  sigStrobes_t       strobes,
  input  logic              blank,
  input  logic [DATA_W-1:0] vidIn,
  input  logic [DATA_W-1:0] defaultVideo,
  output logic [DATA_W-1:0] vidOut,
  output logic [SIG_W-1:0]  sigRead,
  output logic [SIG_W-1:0]  sigValue
);

  localparam int HALF_W = SIG_W / 2;

  logic [SIG_W-1:0] sigQ;
  logic [SIG_W-1:0] tapMask;
  logic             feedback;
  logic [SIG_W-1:0] sigNext;

  // Tap mask built bit by bit from the parameter.
  for (genvar i = 0; i < SIG_W; i++) begin : g_taps
    assign tapMask[i] = (i < 16) ? TAPS[i % 16] : 1'b0;
  end

  always_comb begin
    feedback = ^(sigQ & tapMask);
    sigNext  = {sigQ[SIG_W-2:0], feedback} ^ SIG_W'(vidIn);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sigQ <= '0;
    end else if (strobes.clearSig) begin
      sigQ <= '0;
    end else if (strobes.accumEn) begin
      sigQ <= sigNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sigRead <= '0;
    end else if (strobes.captureRd) begin
      sigRead <= sigQ;
    end
  end

  // Blanking-time source selection.
  logic [HALF_W-1:0] sigHalf;
  logic [DATA_W-1:0] blankByte;
  logic [DATA_W-1:0] outNext;

  always_comb begin
    sigHalf   = strobes.selHigh ? sigQ[SIG_W-1:HALF_W] : sigQ[HALF_W-1:0];
    blankByte = strobes.showSig ? DATA_W'(sigHalf) : defaultVideo;
    outNext   = blank ? blankByte : vidIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vidOut <= '0;
    end else begin
      vidOut <= outNext;
    end
  end

  assign sigValue = sigQ;

endmodule

// File: rtl/vidSigAnalyzer.sv
module vidSigAnalyzer
  import vidSigPkg::*;
#(
  parameter int          DATA_W = 8,
  parameter int          SIG_W  = 16,
  parameter logic [15:0] TAPS   = 16'hB400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] vidIn,
  input  logic              blank,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              testMode,
  input  logic              sigOutEn,
  input  logic [DATA_W-1:0] defaultVideo,
  output logic [DATA_W-1:0] vidOut,
  output logic [SIG_W-1:0]  sigRead
);

  sigStrobes_t      strobes;
  logic [SIG_W-1:0] sigValue;

  vidSigCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .blank    (blank),
    .hsync    (hsync),
    .vsync    (vsync),
    .testMode (testMode),
    .sigOutEn (sigOutEn),
    .strobes  (strobes)
  );

  vidSigDatapath #(
    .DATA_W (DATA_W),
    .SIG_W  (SIG_W),
    .TAPS   (TAPS)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .blank        (blank),
    .vidIn        (vidIn),
    .defaultVideo (defaultVideo),
    .vidOut       (vidOut),
    .sigRead      (sigRead),
    .sigValue     (sigValue)
  );

endmodule

// File: rtl/vidSigChecker.sv
module vidSigChecker #(
  parameter int DATA_W = 8,
  parameter int SIG_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] vidIn,
  input logic              blank,
  input logic              hsync,
  input logic              vsync,
  input logic              testMode,
  input logic              sigOutEn,
  input logic [DATA_W-1:0] defaultVideo,
  input logic [DATA_W-1:0] vidOut,
  input logic [SIG_W-1:0]  sigRead,
  input logic [SIG_W-1:0]  sigValue
);

  localparam int HALF_W = SIG_W / 2;

  // R2: pixels pass through during active display
  a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
    !blank |=> vidOut == $past(vidIn));

  // R4: signature frozen during blanking unless a frame clear occurs
  a_r4_hold_blank: assert property (@(posedge clk) disable iff (rst)
    (blank && !$fell(vsync)) |=> $stable(sigValue));

  // R6: falling vsync zeroes the signature
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync) |=> sigValue == '0);

  // R7: half selection on the pins during blanking in test mode
  a_r7_sig_low: assert property (@(posedge clk) disable iff (rst)
    (blank && testMode && sigOutEn && !hsync) |=>
      vidOut == DATA_W'($past(sigValue[HALF_W-1:0])));

  a_r7_sig_high: assert property (@(posedge clk) disable iff (rst)
    (blank && testMode && sigOutEn && hsync) |=>
      vidOut == DATA_W'($past(sigValue[SIG_W-1:HALF_W])));

  // R8: default byte when the signature is not shown
  a_r8_default: assert property (@(posedge clk) disable iff (rst)
    (blank && !(testMode && sigOutEn)) |=> vidOut == $past(defaultVideo));

  // R9: readback loads on rising vsync and holds otherwise
  a_r9_capture: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |=> sigRead == $past(sigValue));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !$rose(vsync) |=> $stable(sigRead));

endmodule

bind vidSigAnalyzer vidSigChecker #(
  .DATA_W (DATA_W),
  .SIG_W  (SIG_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .vidIn        (vidIn),
  .blank        (blank),
  .hsync        (hsync),
  .vsync        (vsync),
  .testMode     (testMode),
  .sigOutEn     (sigOutEn),
  .defaultVideo (defaultVideo),
  .vidOut       (vidOut),
  .sigRead      (sigRead),
  .sigValue     (sigValue)
);

// File: tb/tb_vidSigAnalyzer.sv
module tb_vidSigAnalyzer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  vidIn = 8'h00;
  logic        blank = 1'b1;
  logic        hsync = 1'b0;
  logic        vsync = 1'b0;
  logic        testMode = 1'b1;
  logic        sigOutEn = 1'b1;
  logic [7:0]  defaultVideo = 8'h5A;
  logic [7:0]  vidOut;
  logic [15:0] sigRead;

  always #4 clk = ~clk;

  vidSigAnalyzer dut (
    .clk(clk), .rst(rst), .vidIn(vidIn), .blank(blank), .hsync(hsync),
    .vsync(vsync), .testMode(testMode), .sigOutEn(sigOutEn),
    .defaultVideo(defaultVideo), .vidOut(vidOut), .sigRead(sigRead)
  );

  int checks = 0;
  int failures = 0;
  string req = "R1";
  bit done = 0;

  // Behavioural reference state
  logic [15:0] refSig = 16'h0;
  logic [15:0] refRead = 16'h0;
  logic [7:0]  refOut = 8'h0;
  logic        prevV = 1'b0;

  function automatic logic [15:0] misrStep(logic [15:0] s, logic [7:0] d);
    int fb;
    int v;
    fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
    v  = ((int'(s) * 2) + fb) % 65536;
    v  = v ^ int'(d);
    return v[15:0];
  endfunction

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // One video clock: drive at negedge, model at posedge, compare at negedge.
  task automatic cycle(bit b, bit h, bit v, logic [7:0] d);
    logic [15:0] nSig;
    logic [15:0] nRead;
    logic [7:0]  nOut;
    blank = b; hsync = h; vsync = v; vidIn = d;
    @(posedge clk);
    if (rst) begin
      nSig = 0; nRead = 0; nOut = 0;
    end else begin
      if (b) begin
        if (testMode && sigOutEn) nOut = h ? refSig[15:8] : refSig[7:0];
        else nOut = defaultVideo;
      end else begin
        nOut = d;
      end
      nRead = (v && !prevV) ? refSig : refRead;
      if (!v && prevV) nSig = 16'h0;
      else if (!b) nSig = misrStep(refSig, d);
      else nSig = refSig;
    end
    prevV = v;
    refSig = nSig; refRead = nRead; refOut = nOut;
    @(negedge clk);
    check(req, int'(vidOut), int'(refOut));
    check(req, int'(sigRead), int'(refRead));
  endtask

  task automatic runFrame(int nLines, int nPix, int seed, bit identical);
    req = "R6";
    cycle(1, 0, 1, 8'h00);
    cycle(1, 0, 1, 8'h00);
    cycle(1, 0, 0, 8'h00);   // falling vsync clears
    cycle(1, 0, 0, 8'h00);   // cleared signature on pins
    for (int l = 0; l < nLines; l++) begin
      req = (l > 0) ? "R5" : "R3";
      for (int p = 0; p < nPix; p++) begin
        int px;
        px = identical ? (p * 37 + seed) : (l * 53 + p * 29 + seed);
        cycle(0, 0, 0, px[7:0]);
      end
      req = (testMode && sigOutEn) ? "R7" : "R8";
      cycle(1, 0, 0, 8'hFF);
      cycle(1, 0, 0, 8'hEE);
      req = "R4";
      cycle(1, 1, 0, 8'h11);
      cycle(1, 1, 0, 8'h22);
      cycle(1, 0, 0, 8'h33);
    end
    req = "R9";
    cycle(1, 0, 1, 8'h00);   // rising vsync captures
    cycle(1, 1, 1, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] frameA;
    @(negedge clk);
    req = "R1";
    cycle(1, 0, 0, 8'hAA);
    cycle(0, 0, 0, 8'hBB);
    cycle(0, 0, 0, 8'hCC);
    check("R1", int'(vidOut), 0);
    check("R1", int'(sigRead), 0);
    rst = 1'b0;

    // R2: pass-through in test mode, signature shown in blanking (R7)
    req = "R2";
    cycle(0, 0, 0, 8'h3C);
    check("R2", int'(vidOut), 8'h3C);

    testMode = 1; sigOutEn = 1;
    runFrame(3, 6, 5, 0);
    frameA = sigRead;
    check("R3", int'(sigRead), int'(refRead));

    // R5: identical lines still keep accumulating
    runFrame(3, 6, 9, 1);
    check("R5", int'(sigRead), int'(refRead));

    // R10: same frame as the first, outside test mode
    testMode = 0; defaultVideo = 8'hC3;
    runFrame(3, 6, 5, 0);
    check("R10", int'(sigRead), int'(frameA));

    // R8: enable set but test mode off, then test mode on with enable off
    sigOutEn = 1; testMode = 0;
    req = "R8";
    cycle(1, 1, 1, 8'h00);
    check("R8", int'(vidOut), 8'hC3);
    testMode = 1; sigOutEn = 0; defaultVideo = 8'h0F;
    runFrame(2, 4, 77, 0);
    cycle(1, 0, 1, 8'h00);
    check("R8", int'(vidOut), 8'h0F);

    // R6: vsync falls during an active pixel - clear wins
    testMode = 1; sigOutEn = 1;
    req = "R6";
    cycle(0, 0, 0, 8'h99);
    cycle(1, 0, 0, 8'h00);
    check("R6", int'(vidOut), 0);

    // R2 with test mode off
    testMode = 0;
    req = "R2";
    cycle(0, 0, 0, 8'h81);
    check("R2", int'(vidOut), 8'h81);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule